// File: doc/BRIEF.md
# Tuning Synthesizer Reference Divider and Phase/Frequency Detector

This block is the digital core of a radio tuning synthesizer. It divides the system crystal clock down to one of twelve reference rates. It divides the local-oscillator event stream down by a programmable ratio, and it compares the two divided strobes in a three-state phase/frequency detector. The detector result steers an external charge pump. The pump is driven up when the divided oscillator runs ahead of the reference, driven down when the reference runs ahead, and left floating when the two arrive together. A sticky flag reports any phase error that persists longer than a fixed run length.

The oscillator input is modelled as a one-cycle tick per oscillator period, already brought into the crystal clock domain. In the FM band the ratio word is split into a main count and a swallow count, which feed a prescaler that switches between divide-by-16 and divide-by-17. In the two AM bands the prescaler is bypassed. The upper AM band halves the tick rate ahead of the programmable counter. Software-level control is reduced to a stop input and an acknowledge input for the unlock flag.

Top module: `tune_pll_pd`

## Requirements
- R1: `ref_sel` codes 0 to 11 give reference periods of 4500, 1500, 1440, 900, 720, 500, 450, 360, 180, 150, 90 and 45 clock cycles. These correspond to 1, 3, 3.125, 5, 6.25, 9, 10, 12.5, 25, 30, 50 and 100 kHz from a 4.5 MHz clock. Codes 12 to 15 behave as code 11.
- R2: When `band_sel` is 00 or 01 (FM), the main count is P = `div_word[15:4]` and the swallow count is S = `div_word[3:0]`. With lo_tick high every cycle, `div_strobe` repeats every 16·P+S cycles, for P ≥ S ≥ 0 and P ≥ 1.
- R3: When `band_sel` is 11, `div_strobe` repeats every N = `div_word` oscillator ticks. When `band_sel` is 10, the ticks are first halved, so the period is 2·N ticks.
- R4: `pump_drive` is 01 (drive high) after a divider strobe that is not yet matched by a reference strobe. It is 10 (drive low) after a reference strobe that is not yet matched by a divider strobe.
- R5: When both strobes arrive in the same cycle, `pump_drive` stays 00 (float). Equal ratios started together therefore never drive the pump.
- R6: During reset and while `pll_stop` is high, `pump_drive` is 00, both strobes are low and both dividers reload. After stop is released, the dividers restart together.
- R7: `pump_drive` never takes the value 11.
- R8: `unlock` sets after `pump_drive` has been non-float for UNLOCK_LIMIT consecutive cycles (8 by default). A run of UNLOCK_LIMIT-1 cycles leaves it clear.
- R9: `unlock` stays set, including through stop, until `unlock_ack` is high for a cycle. It then reads 0 at the next clock edge.
- R10: `ref_strobe` is high for exactly one cycle per reference period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived system clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_tick | input | 1 | One pulse per local-oscillator period |
| div_word | input | N_W | Oscillator divide word (P and S fields in FM) |
| band_sel | input | 2 | 00/01 FM, 10 upper AM, 11 lower AM |
| ref_sel | input | 4 | Reference rate code |
| pll_stop | input | 1 | Holds the synthesizer stopped and floating |
| unlock_ack | input | 1 | Read acknowledge that clears the unlock flag |
| pump_drive | output | 2 | 00 float, 01 drive high, 10 drive low |
| unlock | output | 1 | Sticky loss-of-lock flag |
| ref_strobe | output | 1 | Divided reference pulse |
| div_strobe | output | 1 | Divided oscillator pulse |

## Verification
The bench builds the block with its defaults: N_W = 16 and UNLOCK_LIMIT = 8. The 45-cycle reference and divide words of 34, 48 and 50 put every phase scenario within a few hundred cycles. An unlock limit of 8 lets a deliberate 7-cycle or 8-cycle start-up offset between equal-rate dividers land on either side of the detection threshold. The full twelve-entry reference table stays affordable because the longest ratio is only 4500 cycles.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

    localparam int REF_W = 13;

    typedef enum logic [1:0] {
        PUMP_Z  = 2'b00,
        PUMP_UP = 2'b01,
        PUMP_DN = 2'b10
    } pump_e;

    typedef enum logic [1:0] {
        BAND_FM0 = 2'b00,
        BAND_FM1 = 2'b01,
        BAND_AMH = 2'b10,
        BAND_AML = 2'b11
    } band_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

    // Reference period in clock cycles for a 4.5 MHz crystal
    function automatic logic [REF_W-1:0] ref_ratio(input logic [3:0] code);
        case (code)
            4'd0:    ref_ratio = REF_W'(4500);
            4'd1:    ref_ratio = REF_W'(1500);
            4'd2:    ref_ratio = REF_W'(1440);
            4'd3:    ref_ratio = REF_W'(900);
            4'd4:    ref_ratio = REF_W'(720);
            4'd5:    ref_ratio = REF_W'(500);
            4'd6:    ref_ratio = REF_W'(450);
            4'd7:    ref_ratio = REF_W'(360);
            4'd8:    ref_ratio = REF_W'(180);
            4'd9:    ref_ratio = REF_W'(150);
            4'd10:   ref_ratio = REF_W'(90);
            default: ref_ratio = REF_W'(45);
        endcase
    endfunction

    function automatic pump_e flags_to_pump(input pfd_flags_t f);
        if (f.up)      flags_to_pump = PUMP_UP;
        else if (f.dn) flags_to_pump = PUMP_DN;
        else           flags_to_pump = PUMP_Z;
    endfunction

endpackage

// File: rtl/tpll_ref_div.sv
module tpll_ref_div
    import tpll_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop,
    input  logic [3:0] ref_code,
    output logic       ref_strobe
);
    logic [REF_W-1:0] cnt;
    logic [REF_W-1:0] period_m1;

    always_comb period_m1 = ref_ratio(ref_code) - REF_W'(1);

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            cnt        <= period_m1;
            ref_strobe <= 1'b0;
        end else begin
            ref_strobe <= (cnt == '0);
            cnt        <= (cnt == '0) ? period_m1 : cnt - REF_W'(1);
        end
    end
endmodule

// File: rtl/tpll_lo_div.sv
module tpll_lo_div
    import tpll_pkg::*;
#(
    parameter int N_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stop,
    input  logic           lo_tick,
    input  logic [1:0]     band,
    input  logic [N_W-1:0] div_word,
    output logic           div_strobe
);
    logic [4:0]     pre_cnt;
    logic [3:0]     swl_cnt;
    logic [N_W-1:0] main_cnt;
    logic           half;

    logic           fm_mode;
    logic [N_W-1:0] reload;
    logic [3:0]     swl_reload;
    logic [4:0]     pre_term;
    logic           pre_wrap;
    logic           am_evt;
    logic           main_evt;
    logic           last;

    always_comb begin
        fm_mode    = (band_e'(band) == BAND_FM0) || (band_e'(band) == BAND_FM1);
        reload     = fm_mode ? N_W'(div_word[N_W-1:4]) : div_word;
        swl_reload = fm_mode ? div_word[3:0] : 4'd0;
        // prescaler divides by 17 while swallow count remains, else by 16
        pre_term   = (swl_cnt != 4'd0) ? 5'd16 : 5'd15;
        pre_wrap   = lo_tick && (pre_cnt == pre_term);
        am_evt     = lo_tick && ((band_e'(band) == BAND_AMH) ? half : 1'b1);
        main_evt   = fm_mode ? pre_wrap : am_evt;
        last       = (main_cnt <= N_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            pre_cnt    <= '0;
            swl_cnt    <= swl_reload;
            main_cnt   <= reload;
            half       <= 1'b0;
            div_strobe <= 1'b0;
        end else begin
            div_strobe <= main_evt && last;
            if (lo_tick) begin
                half    <= ~half;
                pre_cnt <= pre_wrap ? 5'd0 : pre_cnt + 5'd1;
            end
            if (main_evt) begin
                if (last) begin
                    main_cnt <= reload;
                    swl_cnt  <= swl_reload;
                end else begin
                    main_cnt <= main_cnt - N_W'(1);
                    if (swl_cnt != 4'd0) swl_cnt <= swl_cnt - 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/tpll_pfd.sv
module tpll_pfd
    import tpll_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stop,
    input  logic  ref_strobe,
    input  logic  div_strobe,
    output pump_e pump
);
    pfd_flags_t flags, flags_nx;

    always_comb begin
        flags_nx.up = flags.up | div_strobe;
        flags_nx.dn = flags.dn | ref_strobe;
        if (flags_nx.up && flags_nx.dn) flags_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || stop) flags <= '0;
        else             flags <= flags_nx;
    end

    always_comb pump = flags_to_pump(flags);
endmodule

// File: rtl/tpll_lock_mon.sv
module tpll_lock_mon
    import tpll_pkg::*;
#(
    parameter int LIMIT = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  pump_e pump,
    input  logic  ack,
    output logic  unlock
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] run_cnt;
    logic          hit;

    always_comb hit = (pump != PUMP_Z) && (run_cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            unlock  <= 1'b0;
        end else begin
            if (pump == PUMP_Z)             run_cnt <= '0;
            else if (run_cnt != CW'(LIMIT)) run_cnt <= run_cnt + CW'(1);
            unlock <= hit | (unlock & ~ack);
        end
    end
endmodule

// File: rtl/tune_pll_pd.sv
module tune_pll_pd
    import tpll_pkg::*;
#(
    parameter int N_W          = 16,
    parameter int UNLOCK_LIMIT = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           lo_tick,
    input  logic [N_W-1:0] div_word,
    input  logic [1:0]     band_sel,
    input  logic [3:0]     ref_sel,
    input  logic           pll_stop,
    input  logic           unlock_ack,
    output logic [1:0]     pump_drive,
    output logic           unlock,
    output logic           ref_strobe,
    output logic           div_strobe
);
    pump_e pump;

    tpll_ref_div u_ref (
        .clk(clk), .rst(rst), .stop(pll_stop),
        .ref_code(ref_sel), .ref_strobe(ref_strobe)
    );

    tpll_lo_div #(.N_W(N_W)) u_lo (
        .clk(clk), .rst(rst), .stop(pll_stop), .lo_tick(lo_tick),
        .band(band_sel), .div_word(div_word), .div_strobe(div_strobe)
    );

    tpll_pfd u_pfd (
        .clk(clk), .rst(rst), .stop(pll_stop),
        .ref_strobe(ref_strobe), .div_strobe(div_strobe), .pump(pump)
    );

    tpll_lock_mon #(.LIMIT(UNLOCK_LIMIT)) u_lock (
        .clk(clk), .rst(rst), .pump(pump), .ack(unlock_ack), .unlock(unlock)
    );

    assign pump_drive = pump;
endmodule

// File: rtl/tune_pll_pd_chk.sv
module tune_pll_pd_chk (
    input logic       clk,
    input logic       rst,
    input logic       lo_tick,
    input logic       pll_stop,
    input logic       unlock_ack,
    input logic [1:0] pump_drive,
    input logic       unlock,
    input logic       ref_strobe,
    input logic       div_strobe
);
    assert_pump_legal_R7: assert property (@(posedge clk) disable iff (rst)
        pump_drive != 2'b11);

    assert_stop_float_R6: assert property (@(posedge clk) disable iff (rst)
        pll_stop |=> pump_drive == 2'b00);

    assert_reset_state_R6: assert property (@(posedge clk)
        rst |=> (pump_drive == 2'b00 && !unlock && !ref_strobe && !div_strobe));

    assert_unlock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (unlock && !unlock_ack) |=> unlock);

    assert_unlock_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock) |-> $past(pump_drive) != 2'b00);

    assert_ref_single_R10: assert property (@(posedge clk) disable iff (rst)
        ref_strobe |=> !ref_strobe);

    assert_div_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
        div_strobe |-> $past(lo_tick));
endmodule

bind tune_pll_pd tune_pll_pd_chk u_chk (
    .clk(clk), .rst(rst), .lo_tick(lo_tick), .pll_stop(pll_stop),
    .unlock_ack(unlock_ack), .pump_drive(pump_drive), .unlock(unlock),
    .ref_strobe(ref_strobe), .div_strobe(div_strobe)
);

// File: tb/tune_pll_pd_bench.sv
module tune_pll_pd_bench;
    localparam int N_W = 16;
    localparam int LIM = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           lo_tick = 1'b0;
    logic           pll_stop = 1'b0;
    logic           unlock_ack = 1'b0;
    logic [N_W-1:0] div_word = '0;
    logic [1:0]     band_sel = 2'b00;
    logic [3:0]     ref_sel = 4'd11;
    logic [1:0]     pump_drive;
    logic           unlock, ref_strobe, div_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tune_pll_pd #(.N_W(N_W), .UNLOCK_LIMIT(LIM)) u_tune_pll_pd (
        .clk(clk), .rst(rst), .lo_tick(lo_tick), .div_word(div_word),
        .band_sel(band_sel), .ref_sel(ref_sel), .pll_stop(pll_stop),
        .unlock_ack(unlock_ack), .pump_drive(pump_drive), .unlock(unlock),
        .ref_strobe(ref_strobe), .div_strobe(div_strobe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ratio(input int code);
        int f8 [12] = '{8, 24, 25, 40, 50, 72, 80, 100, 200, 240, 400, 800};
        int idx = (code > 11) ? 11 : code;
        return 36000 / f8[idx];
    endfunction

    task automatic apply_reset(input bit tick);
        @(negedge clk);
        rst = 1'b1;
        lo_tick = tick;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic restart_stop;
        pll_stop = 1'b1;
        @(negedge clk);
        pll_stop = 1'b0;
    endtask

    function automatic logic pick(input bit use_ref);
        return use_ref ? ref_strobe : div_strobe;
    endfunction

    task automatic measure(input bit use_ref, output int period);
        int guard = 0;
        while (!pick(use_ref) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        period = 1;
        while (!pick(use_ref) && period < 20000) begin
            @(negedge clk);
            period++;
        end
    endtask

    task automatic observe(input int n, output int ups, output int dns, output int bad);
        ups = 0; dns = 0; bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (pump_drive == 2'b01) ups++;
            if (pump_drive == 2'b10) dns++;
            if (pump_drive == 2'b11) bad++;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        lo_tick = 1'b1;
        repeat (4) @(negedge clk);
        check(pump_drive == 2'b00, "R6 reset pump float", pump_drive, 0);
        check(unlock == 1'b0, "R6 reset unlock clear", unlock, 0);
        check(!ref_strobe && !div_strobe, "R6 reset strobes low", ref_strobe, 0);
        rst = 1'b0;
    endtask

    task automatic t_ref_table;
        int p;
        lo_tick = 1'b0;
        for (int c = 0; c < 16; c++) begin
            if (c <= 12 || c == 15) begin
                ref_sel = 4'(c);
                restart_stop();
                measure(1'b1, p);
                check(p == exp_ratio(c), $sformatf("R1 ref period code %0d", c), p, exp_ratio(c));
                @(negedge clk);
                check(!ref_strobe, "R10 ref strobe one cycle", ref_strobe, 0);
            end
        end
        ref_sel = 4'd11;
    endtask

    task automatic t_div_ratio(input logic [1:0] band, input int word, input int expect_p, input string tag);
        int p;
        band_sel = band;
        div_word = N_W'(word);
        lo_tick = 1'b1;
        restart_stop();
        measure(1'b0, p);
        measure(1'b0, p);
        check(p == expect_p, tag, p, expect_p);
    endtask

    task automatic t_pfd_fm(input int word, input bit faster);
        int u, d, b;
        band_sel = 2'b00;
        div_word = N_W'(word);
        ref_sel = 4'd11;
        apply_reset(1'b1);
        observe(600, u, d, b);
        check(b == 0, "R7 no illegal pump code", b, 0);
        if (faster) begin
            check(u > 0, "R4 fast divider drives high", u, 1);
            check(d == 0, "R4 fast divider never low", d, 0);
            check(unlock == 1'b1, "R8 long error sets unlock", unlock, 1);
        end else begin
            check(d > 0, "R4 slow divider drives low", d, 1);
            check(u == 0, "R4 slow divider never high", u, 0);
        end
    endtask

    task automatic t_lock;
        int u, d, b;
        band_sel = 2'b11;
        div_word = N_W'(45);
        ref_sel = 4'd11;
        apply_reset(1'b1);
        observe(600, u, d, b);
        check(u + d + b == 0, "R5 matched rates float", u + d + b, 0);
        check(unlock == 1'b0, "R5 matched rates stay locked", unlock, 0);
    endtask

    task automatic t_limit(input int off);
        int u, d, b;
        band_sel = 2'b11;
        div_word = N_W'(45);
        ref_sel = 4'd11;
        apply_reset(1'b0);
        repeat (off) @(negedge clk);
        lo_tick = 1'b1;
        observe(300, u, d, b);
        check(d > 0 && u == 0, $sformatf("R4 lagging divider offset %0d drives low", off), d, 1);
        check(unlock == (off >= LIM), $sformatf("R8 unlock for offset %0d", off), unlock, (off >= LIM) ? 1 : 0);
    endtask

    task automatic t_unlock_clear;
        int u, d, b;
        pll_stop = 1'b1;
        observe(5, u, d, b);
        check(u + d + b == 0, "R6 stop floats pump", u + d + b, 0);
        check(unlock == 1'b1, "R9 stop keeps unlock", unlock, 1);
        unlock_ack = 1'b1;
        @(negedge clk);
        unlock_ack = 1'b0;
        check(unlock == 1'b0, "R9 ack clears unlock", unlock, 0);
        pll_stop = 1'b0;
        observe(300, u, d, b);
        check(u + d == 0, "R6 aligned restart after stop", u + d, 0);
        check(unlock == 1'b0, "R9 unlock stays clear", unlock, 0);
    endtask

    initial begin
        t_reset();
        t_ref_table();
        t_div_ratio(2'b00, (2 << 4) | 2, 34, "R2 FM P=2 S=2");
        t_div_ratio(2'b00, (3 << 4) | 0, 48, "R2 FM P=3 S=0");
        t_div_ratio(2'b01, (3 << 4) | 2, 50, "R2 FM band 01 P=3 S=2");
        t_div_ratio(2'b11, 20, 20, "R3 lower AM direct");
        t_div_ratio(2'b10, 20, 40, "R3 upper AM halved");
        t_pfd_fm((2 << 4) | 2, 1'b1);
        t_pfd_fm((3 << 4) | 2, 1'b0);
        t_lock();
        t_limit(LIM - 1);
        t_limit(LIM);
        t_unlock_clear();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule